// File: doc/BRIEF.md
# Mode-Selectable Sequential Cell

This block is a single storage element that follows a pair of lookup-table outputs. A 2-bit mode input picks the kind of storage at run time: a gated D flip-flop, a JK flip-flop, a gated D-latch or a set/reset latch. The even data input feeds the D, J or S pin, depending on the mode. The odd data input feeds the G, K or R pin. The block runs on the bus clock. The logic clock reaches it as a one-cycle rising-edge strobe, and the two flip-flop modes update only when that strobe is high. The two latch modes are level-sensitive and are re-evaluated on every bus-clock cycle.

An enable flag for the even table controls clearing. A falling edge on that flag starts a clear pulse that lasts exactly one bus cycle. In the flip-flop modes the pulse clears the output at once. In the latch modes it forces the gate or reset pin on, and the data or set pin off, for that one cycle, so the output clears one cycle later. In the set/reset latch, driving both pins high gives a defined result: the output is 0 and an error flag is raised.

Top module: `seq_cell`

## Requirements
- R1: After reset, q_o is 0 and err_o is 0.
- R2: mode_i selects the storage type with this encoding: 0 gives the D flip-flop, 1 the JK flip-flop, 2 the D-latch and 3 the RS latch. even_i drives D/J/S and odd_i drives G/K/R.
- R3: In mode 0, on a bus edge where lclk_rise_i is 1 and odd_i is 1, q_o takes the value of even_i. On any other edge q_o holds.
- R4: In mode 1, on a bus edge where lclk_rise_i is 1, the pair (even_i, odd_i) acts as follows: (0,0) holds, (0,1) clears, (1,0) sets and (1,1) toggles. Without the strobe, q_o holds.
- R5: In mode 2, on every bus edge, q_o takes even_i when odd_i is 1 and holds when odd_i is 0. The strobe has no effect.
- R6: In mode 3, on every bus edge, even_i alone sets q_o, odd_i alone clears it, and neither pin holds it.
- R7: In mode 3, when both pins are 1 at an edge, q_o becomes 0 and err_o is 1 for the following cycle. err_o returns to 0 once that combination is gone.
- R8: In modes 0 and 1, an edge that samples even_en_i at 0 after it was 1 starts a one-cycle clear. q_o reads 0 right after that edge, and any strobe during the clear cycle is ignored.
- R9: In modes 2 and 3, the same clear forces G or R to 1 and D or S to 0 for one cycle. q_o therefore keeps its value for one cycle and reads 0 after the next edge.
- R10: While even_en_i is 0, even_i is treated as 0 in every mode.
- R11: Changing mode_i leaves the stored value unchanged until the new mode updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lclk_rise_i | input | 1 | Logic-clock rising-edge strobe, one bus cycle wide |
| mode_i | input | 2 | Storage type select |
| even_en_i | input | 1 | Enable flag of the even lookup table |
| even_i | input | 1 | Even table output (D/J/S) |
| odd_i | input | 1 | Odd table output (G/K/R) |
| q_o | output | 1 | Cell output |
| err_o | output | 1 | Both RS pins were high at the previous edge |

## Verification
The hardest case to reach is the clear sequence while the cell holds a 1. The stimulus first loads a 1 through each mode's normal path. It then drops the even enable while the other inputs would, if honoured, set or keep the output high. Only then can the bench tell the immediate clear of the flip-flop modes apart from the one-cycle-late clear of the latch modes. A strobe held high during the clear cycle, and re-enabling the table after the pulse, confirm that the pulse is exactly one cycle wide and that the gated even input stays at 0 while the table is disabled.

// File: rtl/seq_cell_pkg.sv
package seq_cell_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_DFF  = 2'd0,
    MODE_JK   = 2'd1,
    MODE_DLAT = 2'd2,
    MODE_RS   = 2'd3
  } cell_mode_e;

  function automatic logic is_latch(cell_mode_e m);
    return m[MODE_W-1];
  endfunction
endpackage

// File: rtl/seq_cell_clr.sv
module seq_cell_clr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clr_o
);
  logic en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d  <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      en_d  <= en_i;
      clr_o <= en_d & ~en_i;
    end
  end

  // R8
  clr_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);
endmodule

// File: rtl/seq_cell_route.sv
module seq_cell_route
  import seq_cell_pkg::*;
(
  input  cell_mode_e mode_i,
  input  logic       clr_i,
  input  logic       even_en_i,
  input  logic       even_i,
  input  logic       odd_i,
  output logic       a_o,
  output logic       b_o
);
  logic force_l;
  assign force_l = clr_i & is_latch(mode_i);

  // latch clear: data/set low, gate/reset high
  always_comb begin
    a_o = even_i & even_en_i;
    b_o = odd_i;
    if (force_l) begin
      a_o = 1'b0;
      b_o = 1'b1;
    end
  end
endmodule

// File: rtl/seq_cell_core.sv
module seq_cell_core
  import seq_cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cell_mode_e mode_i,
  input  logic       strobe_i,
  input  logic       clr_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       q_o,
  output logic       err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= 1'b0;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (clr_i && !is_latch(mode_i)) begin
        q_o <= 1'b0;
      end else begin
        unique case (mode_i)
          MODE_DFF:  if (strobe_i && b_i) q_o <= a_i;
          MODE_JK: begin
            if (strobe_i) begin
              unique case ({a_i, b_i})
                2'b01:   q_o <= 1'b0;
                2'b10:   q_o <= 1'b1;
                2'b11:   q_o <= ~q_o;
                default: q_o <= q_o;
              endcase
            end
          end
          MODE_DLAT: if (b_i) q_o <= a_i;
          MODE_RS: begin
            if (a_i && b_i) begin
              q_o   <= 1'b0;
              err_o <= 1'b1;
            end else if (a_i) begin
              q_o <= 1'b1;
            end else if (b_i) begin
              q_o <= 1'b0;
            end
          end
          default: q_o <= q_o;
        endcase
      end
    end
  end

  // R8
  ff_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !is_latch(mode_i)) |=> !q_o);
  // R3
  dff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DFF && !clr_i && !(strobe_i && b_i)) |=> $stable(q_o));
  // R4
  jk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_JK && strobe_i && a_i && b_i && !clr_i) |=> (q_o != $past(q_o)));
  // R5
  dlat_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DLAT && b_i) |=> (q_o == $past(a_i)));
  // R7
  rs_forbid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RS && a_i && b_i) |=> (err_o && !q_o));
endmodule

// File: rtl/seq_cell.sv
module seq_cell
  import seq_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lclk_rise_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              even_en_i,
  input  logic              even_i,
  input  logic              odd_i,
  output logic              q_o,
  output logic              err_o
);
  cell_mode_e mode;
  logic clr, a, b, q_r;

  assign mode = cell_mode_e'(mode_i);

  seq_cell_clr u_clr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (even_en_i),
    .clr_o (clr)
  );

  seq_cell_route u_route (
    .mode_i   (mode),
    .clr_i    (clr),
    .even_en_i(even_en_i),
    .even_i   (even_i),
    .odd_i    (odd_i),
    .a_o      (a),
    .b_o      (b)
  );

  seq_cell_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .strobe_i(lclk_rise_i),
    .clr_i   (clr),
    .a_i     (a),
    .b_i     (b),
    .q_o     (q_r),
    .err_o   (err_o)
  );

  // flip-flop modes clear without waiting for an edge
  assign q_o = q_r & ~(clr & ~is_latch(mode));
endmodule

// File: tb/seq_cell_tb.sv
module seq_cell_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, en = 1'b0, ev = 1'b0, od = 1'b0;
  logic [1:0] mode = 2'd0;
  logic q, err;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_cell u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lclk_rise_i(strobe), .mode_i(mode),
    .even_en_i(en), .even_i(ev), .odd_i(od), .q_o(q), .err_o(err)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic s, input logic e, input logic x, input logic y);
    strobe = s; en = e; ev = x; od = y;
  endtask

  task automatic t_reset();
    check("R1 q", q, 1'b0);
    check("R1 err", err, 1'b0);
  endtask

  task automatic t_dff();
    mode = 2'd0;
    drive(0, 1, 1, 1); step(); check("R3 no strobe", q, 1'b0);
    drive(1, 1, 1, 1); step(); check("R3 load 1", q, 1'b1);
    drive(1, 1, 0, 0); step(); check("R3 G low holds", q, 1'b1);
    drive(1, 1, 0, 1); step(); check("R3 load 0", q, 1'b0);
  endtask

  task automatic t_jk();
    mode = 2'd1;
    drive(1, 1, 1, 0); step(); check("R4 set", q, 1'b1);
    drive(1, 1, 1, 1); step(); check("R4 toggle", q, 1'b0);
    drive(1, 1, 1, 1); step(); check("R4 toggle again", q, 1'b1);
    drive(1, 1, 0, 0); step(); check("R4 hold", q, 1'b1);
    drive(0, 1, 0, 1); step(); check("R4 no strobe", q, 1'b1);
    drive(1, 1, 0, 1); step(); check("R4 clear", q, 1'b0);
  endtask

  task automatic t_dlat();
    mode = 2'd2;
    drive(0, 1, 1, 1); step(); check("R5 follow 1", q, 1'b1);
    drive(0, 1, 0, 1); step(); check("R5 follow 0", q, 1'b0);
    drive(1, 1, 1, 0); step(); check("R5 G low holds", q, 1'b0);
    drive(0, 1, 1, 1); step(); check("R5 follow again", q, 1'b1);
  endtask

  task automatic t_rs();
    mode = 2'd3;
    drive(0, 1, 0, 1); step(); check("R6 reset", q, 1'b0);
    drive(0, 1, 1, 0); step(); check("R6 set", q, 1'b1);
    check("R7 no err", err, 1'b0);
    drive(0, 1, 0, 0); step(); check("R6 hold", q, 1'b1);
    drive(0, 1, 1, 1); step(); check("R7 forbidden q", q, 1'b0);
    check("R7 err", err, 1'b1);
    drive(0, 1, 1, 0); step(); check("R7 err clears", err, 1'b0);
    check("R6 set after", q, 1'b1);
  endtask

  task automatic t_ff_clear();
    mode = 2'd0;
    drive(1, 1, 1, 1); step(); check("R3 preload", q, 1'b1);
    drive(1, 0, 1, 1); step(); check("R8 immediate clear", q, 1'b0);
    step(); check("R10 gated even", q, 1'b0);
    drive(1, 1, 1, 1); step(); check("R8 re-enable load", q, 1'b1);
    mode = 2'd1;
    drive(1, 0, 1, 0); step(); check("R8 JK clear", q, 1'b0);
    drive(1, 0, 1, 0); step(); check("R10 JK gated J", q, 1'b0);
    drive(0, 1, 0, 0); step();
  endtask

  task automatic t_latch_clear();
    mode = 2'd2;
    drive(0, 1, 1, 1); step(); check("R5 preload", q, 1'b1);
    drive(0, 0, 1, 0); step(); check("R9 dlat one cycle late", q, 1'b1);
    step(); check("R9 dlat cleared", q, 1'b0);
    drive(0, 0, 1, 1); step(); check("R10 dlat gated D", q, 1'b0);
    mode = 2'd3;
    drive(0, 1, 1, 0); step(); check("R6 preload", q, 1'b1);
    drive(0, 0, 0, 0); step(); check("R9 rs one cycle late", q, 1'b1);
    step(); check("R9 rs cleared", q, 1'b0);
    check("R9 no err", err, 1'b0);
    drive(0, 0, 1, 0); step(); check("R10 rs gated S", q, 1'b0);
    drive(0, 1, 0, 0); step();
  endtask

  task automatic t_mode_switch();
    mode = 2'd2;
    drive(0, 1, 1, 1); step(); check("R11 preload", q, 1'b1);
    mode = 2'd0;
    drive(0, 1, 0, 1); step(); check("R11 to DFF keeps", q, 1'b1);
    mode = 2'd1;
    drive(0, 1, 0, 1); step(); check("R11 to JK keeps", q, 1'b1);
    mode = 2'd3;
    drive(0, 1, 0, 0); step(); check("R2 RS holds", q, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 10000);
    bad++;
    total++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_dff();
    t_jk();
    t_dlat();
    t_rs();
    t_ff_clear();
    t_latch_clear();
    t_mode_switch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule